// File: doc/BRIEF.md
# Transmit Clock Watchdog and Line Driver Enable

This block runs on the master clock of a multi-channel line interface. Each channel's transmit clock is synchronised into the master clock domain. A saturating counter measures how long that clock has gone without changing level. Once the clock has held one level for more than the configured number of master cycles, the channel is marked as having lost its transmit clock. The loss sets a sticky interrupt status bit, and the interrupt output follows that bit unless the channel's mask bit is set.

For each channel the block also produces a driver enable that the line output stage uses to leave high impedance. The enable is dropped by any of the following:
- a global tri-state pin;
- the channel's tri-state register bit;
- master clock loss;
- transmit clock loss, unless the channel is in remote loopback or is sending an internally generated pattern timed from the master clock;
- the channel's power-down;
- any reset.

After a reset the drivers stay off until software clears the channel's tri-state bit.

Top module: `line_drv_guard`

## Requirements
- R1: A channel's transmit clock is reported lost (tclk_lost_o bit = 1) once it has held a constant level, high or low, for more than STUCK_LIMIT (70) master clock cycles plus at most three cycles of synchroniser latency. A clock that keeps toggling is never reported lost.
- R2: A lost flag clears within four master cycles of the first transmit clock transition after recovery.
- R3: While hz_all_i is 1, drv_en_o is 0 for every channel.
- R4: hz_bit_i[n] = 1 forces drv_en_o[n] to 0 and leaves the other channels' enables unaffected.
- R5: While mclk_lost_i is 1, drv_en_o is 0 for every channel.
- R6: A lost transmit clock forces drv_en_o[n] to 0 unless rlb_i[n] or patt_i[n] is 1, in which case the loss has no effect on the enable.
- R7: pwr_down_i[n] = 1 forces drv_en_o[n] to 0.
- R8: After a pin reset (rst_ni low) or a soft reset (soft_rst_i high), drv_en_o is 0 and stays 0 until the first cycle after hz_bit_i[n] is sampled 0. A soft reset also clears the lost flags and status bits.
- R9: irq_sts_o[n] is set in the same cycle tclk_lost_o[n] rises. It stays set after the clock recovers and is cleared by a one-cycle irq_clr_i[n] pulse. When a rise and a clear strobe fall in the same cycle, the set wins.
- R10: irq_o[n] equals irq_sts_o[n] AND NOT irq_mask_i[n].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low pin / power-on reset |
| soft_rst_i | input | 1 | Synchronous software reset |
| tclk_i | input | N_CH | Transmit clocks, one per channel |
| hz_all_i | input | 1 | Global tri-state pin |
| hz_bit_i | input | N_CH | Per-channel tri-state register bits |
| mclk_lost_i | input | 1 | Master clock loss flag |
| pwr_down_i | input | N_CH | Per-channel transmit power-down |
| rlb_i | input | N_CH | Per-channel remote loopback active |
| patt_i | input | N_CH | Per-channel internal pattern timed from master clock |
| irq_mask_i | input | N_CH | Per-channel interrupt mask, 1 = masked |
| irq_clr_i | input | N_CH | Per-channel write-one-to-clear strobe for status |
| tclk_lost_o | output | N_CH | Transmit clock lost flags |
| irq_sts_o | output | N_CH | Sticky lost-clock status bits |
| irq_o | output | N_CH | Per-channel interrupt outputs |
| drv_en_o | output | N_CH | Line driver enable, 0 = high impedance |

## Verification
The rising edge of a lost flag and the write-one-to-clear strobe for that channel's status bit can arrive on the same master clock edge. The bench holds the clear strobe high while a channel's clock is stuck and polls the lost flag every cycle. In the first cycle the flag reads 1, the status bit must also read 1, which shows that the set won. One cycle later, with the strobe still high, the status bit must read 0.

// File: rtl/ldg_pkg.sv
package ldg_pkg;

    // Counter width that can hold limit+1 (saturation value)
    function automatic int unsigned cnt_bits(input int unsigned limit);
        return $clog2(limit + 2);
    endfunction

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

endpackage

// File: rtl/ldg_edge_sync.sv
module ldg_edge_sync
    import ldg_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic soft_rst_i,
    input  logic tclk_i,
    output logic edge_o
);

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (soft_rst_i) begin
            st_d = '0;
        end else begin
            st_d.s1 = tclk_i;
            st_d.s2 = st_q.s1;
            st_d.s3 = st_q.s2;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign edge_o = st_q.s2 ^ st_q.s3;

endmodule

// File: rtl/ldg_stuck_mon.sv
module ldg_stuck_mon
    import ldg_pkg::*;
#(
    parameter int unsigned STUCK_LIMIT = 70
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic soft_rst_i,
    input  logic edge_i,
    input  logic clr_i,
    output logic lost_o,
    output logic sts_o
);

    localparam int unsigned CW = cnt_bits(STUCK_LIMIT);
    localparam logic [CW-1:0] LIM = CW'(STUCK_LIMIT);
    localparam logic [CW-1:0] SAT = CW'(STUCK_LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lost;
        logic          sts;
    } mon_t;

    mon_t mon_d, mon_q;
    logic set_evt;

    always_comb begin
        mon_d   = mon_q;
        set_evt = 1'b0;
        if (soft_rst_i) begin
            mon_d = '0;
        end else begin
            if (edge_i) begin
                mon_d.cnt  = '0;
                mon_d.lost = 1'b0;
            end else if (mon_q.cnt != SAT) begin
                mon_d.cnt = mon_q.cnt + 1'b1;
                if (mon_q.cnt == LIM) begin
                    mon_d.lost = 1'b1;
                    set_evt    = 1'b1;
                end
            end
            // set has priority over a simultaneous clear strobe
            mon_d.sts = (mon_q.sts & ~clr_i) | set_evt;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mon_q <= '0;
        else         mon_q <= mon_d;
    end

    assign lost_o = mon_q.lost;
    assign sts_o  = mon_q.sts;

endmodule

// File: rtl/ldg_hz_merge.sv
module ldg_hz_merge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic soft_rst_i,
    input  logic hz_all_i,
    input  logic hz_bit_i,
    input  logic mclk_lost_i,
    input  logic pwr_down_i,
    input  logic rlb_i,
    input  logic patt_i,
    input  logic lost_i,
    output logic drv_en_o
);

    logic hold_d, hold_q;
    logic lost_eff;

    always_comb begin
        hold_d = hold_q;
        if (soft_rst_i)     hold_d = 1'b1;
        else if (!hz_bit_i) hold_d = 1'b0;

        // transmit clock loss is ignored when timing comes from elsewhere
        lost_eff = lost_i & ~(rlb_i | patt_i);

        drv_en_o = ~(hz_all_i | mclk_lost_i | hz_bit_i | pwr_down_i |
                     hold_q | soft_rst_i | lost_eff);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hold_q <= 1'b1;
        else         hold_q <= hold_d;
    end

endmodule

// File: rtl/line_drv_guard.sv
module line_drv_guard #(
    parameter int unsigned N_CH        = 2,
    parameter int unsigned STUCK_LIMIT = 70
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            soft_rst_i,
    input  logic [N_CH-1:0] tclk_i,
    input  logic            hz_all_i,
    input  logic [N_CH-1:0] hz_bit_i,
    input  logic            mclk_lost_i,
    input  logic [N_CH-1:0] pwr_down_i,
    input  logic [N_CH-1:0] rlb_i,
    input  logic [N_CH-1:0] patt_i,
    input  logic [N_CH-1:0] irq_mask_i,
    input  logic [N_CH-1:0] irq_clr_i,
    output logic [N_CH-1:0] tclk_lost_o,
    output logic [N_CH-1:0] irq_sts_o,
    output logic [N_CH-1:0] irq_o,
    output logic [N_CH-1:0] drv_en_o
);

    logic [N_CH-1:0] edge_w;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        ldg_edge_sync u_sync (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .soft_rst_i (soft_rst_i),
            .tclk_i     (tclk_i[c]),
            .edge_o     (edge_w[c])
        );

        ldg_stuck_mon #(.STUCK_LIMIT(STUCK_LIMIT)) u_mon (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .soft_rst_i (soft_rst_i),
            .edge_i     (edge_w[c]),
            .clr_i      (irq_clr_i[c]),
            .lost_o     (tclk_lost_o[c]),
            .sts_o      (irq_sts_o[c])
        );

        ldg_hz_merge u_hz (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .soft_rst_i  (soft_rst_i),
            .hz_all_i    (hz_all_i),
            .hz_bit_i    (hz_bit_i[c]),
            .mclk_lost_i (mclk_lost_i),
            .pwr_down_i  (pwr_down_i[c]),
            .rlb_i       (rlb_i[c]),
            .patt_i      (patt_i[c]),
            .lost_i      (tclk_lost_o[c]),
            .drv_en_o    (drv_en_o[c])
        );
    end

    assign irq_o = irq_sts_o & ~irq_mask_i;

endmodule

// File: rtl/ldg_checks.sv
module ldg_checks #(
    parameter int unsigned N_CH = 2
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            soft_rst_i,
    input logic            hz_all_i,
    input logic [N_CH-1:0] hz_bit_i,
    input logic            mclk_lost_i,
    input logic [N_CH-1:0] pwr_down_i,
    input logic [N_CH-1:0] rlb_i,
    input logic [N_CH-1:0] patt_i,
    input logic [N_CH-1:0] irq_mask_i,
    input logic [N_CH-1:0] tclk_lost_o,
    input logic [N_CH-1:0] irq_sts_o,
    input logic [N_CH-1:0] irq_o,
    input logic [N_CH-1:0] drv_en_o
);

    AST_GLOBAL_HZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hz_all_i |-> (drv_en_o == '0)); // R3

    AST_CHAN_HZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((drv_en_o & hz_bit_i) == '0)); // R4

    AST_MCLK_HZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mclk_lost_i |-> (drv_en_o == '0)); // R5

    AST_LOST_HZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((drv_en_o & tclk_lost_o & ~(rlb_i | patt_i)) == '0)); // R6

    AST_PWR_HZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((drv_en_o & pwr_down_i) == '0)); // R7

    AST_SOFT_RESET_HZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soft_rst_i |=> (drv_en_o == '0)); // R8

    AST_STICKY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((tclk_lost_o & ~$past(tclk_lost_o) & ~irq_sts_o) == '0)); // R9

    AST_IRQ_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((irq_o & (irq_mask_i | ~irq_sts_o)) == '0)); // R10

endmodule

bind line_drv_guard ldg_checks #(.N_CH(N_CH)) u_chk (.*);

// File: tb/line_drv_guard_test.sv
`timescale 1ns/1ps
module line_drv_guard_test;

    logic clk = 1'b0;
    always #4 clk = ~clk; // 125 MHz

    logic       rst_n = 1'b0, soft_rst = 1'b0, hz_all = 1'b0, mclk_lost = 1'b0;
    logic [1:0] hz_bit = 2'b11, pwr = '0, rlb = '0, patt = '0, mask = '0, clr = '0;
    logic       t0 = 1'b0, t1 = 1'b0, run0 = 1'b1, run1 = 1'b1, lvl0 = 1'b0, lvl1 = 1'b0;
    logic [1:0] lost, sts, irq, en;
    int         checks = 0, errors = 0;

    always begin #20; if (run0) t0 = ~t0; else t0 = lvl0; end
    always begin #28; if (run1) t1 = ~t1; else t1 = lvl1; end

    line_drv_guard uut (
        .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .tclk_i({t1, t0}),
        .hz_all_i(hz_all), .hz_bit_i(hz_bit), .mclk_lost_i(mclk_lost),
        .pwr_down_i(pwr), .rlb_i(rlb), .patt_i(patt), .irq_mask_i(mask),
        .irq_clr_i(clr), .tclk_lost_o(lost), .irq_sts_o(sts), .irq_o(irq),
        .drv_en_o(en)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic t_reset;
        #1;
        chk("R8 en in reset", en, 2'b00);
        chk("R1 lost in reset", lost, 2'b00);
        chk("R9 sts in reset", sts, 2'b00);
        chk("R10 irq in reset", irq, 2'b00);
        tick(1); rst_n = 1'b1; tick(3);
        chk("R8 hold while hz bits set", en, 2'b00);
        hz_bit = 2'b00; #1;
        chk("R8 hold before bit sampled", en, 2'b00);
        tick(1);
        chk("R8 enable after bits cleared", en, 2'b11);
        tick(40);
        chk("R1 toggling clocks not lost", lost, 2'b00);
    endtask

    task automatic t_static_hz;
        hz_all = 1'b1; #1; chk("R3 global tri-state", en, 2'b00);
        hz_all = 1'b0; #1; chk("R3 global released", en, 2'b11);
        hz_bit = 2'b01; #1; chk("R4 ch0 bit only", en, 2'b10);
        hz_bit = 2'b10; #1; chk("R4 ch1 bit only", en, 2'b01);
        hz_bit = 2'b00; #1;
        mclk_lost = 1'b1; #1; chk("R5 master clock loss", en, 2'b00);
        mclk_lost = 1'b0; #1;
        pwr = 2'b10; #1; chk("R7 ch1 power down", en, 2'b01);
        pwr = 2'b00; #1; chk("R7 power restored", en, 2'b11);
    endtask

    task automatic t_stuck_high;
        lvl0 = 1'b1; run0 = 1'b0;
        tick(60);
        chk("R1 not lost before limit", lost, 2'b00);
        tick(20);
        chk("R1 ch0 stuck high lost", lost, 2'b01);
        chk("R6 ch0 driver off", en, 2'b10);
        chk("R9 ch0 status set", sts, 2'b01);
        chk("R10 irq unmasked", irq, 2'b01);
        mask = 2'b01; #1; chk("R10 irq masked", irq, 2'b00);
        mask = 2'b00;
        rlb = 2'b01; #1; chk("R6 loss ignored in loopback", en, 2'b11);
        rlb = 2'b00; patt = 2'b01; #1; chk("R6 loss ignored with pattern", en, 2'b11);
        patt = 2'b00; #1; chk("R6 loss applies again", en, 2'b10);
        run0 = 1'b1;
        tick(8);
        chk("R2 ch0 lost cleared after edge", lost, 2'b00);
        chk("R9 status sticky after recovery", sts, 2'b01);
        clr = 2'b01; tick(1); clr = 2'b00;
        chk("R9 status cleared by strobe", sts, 2'b00);
    endtask

    task automatic t_collide;
        bit seen = 1'b0;
        clr = 2'b10; lvl1 = 1'b0; run1 = 1'b0;
        for (int i = 0; i < 120 && !seen; i++) begin
            tick(1);
            if (lost[1]) seen = 1'b1;
        end
        chk("R1 ch1 stuck low lost", lost, 2'b10);
        chk("R9 set wins over clear", sts, 2'b10);
        tick(1);
        chk("R9 clear acts next cycle", sts, 2'b00);
        clr = 2'b00; run1 = 1'b1;
        tick(8);
        chk("R2 ch1 lost cleared", lost, 2'b00);
    endtask

    task automatic t_soft_reset;
        lvl0 = 1'b0; run0 = 1'b0;
        tick(85);
        chk("R1 ch0 stuck low lost", lost, 2'b01);
        soft_rst = 1'b1; tick(1);
        chk("R8 soft reset drivers off", en, 2'b00);
        chk("R8 soft reset clears lost", lost, 2'b00);
        chk("R8 soft reset clears status", sts, 2'b00);
        soft_rst = 1'b0; run0 = 1'b1;
        tick(2);
        chk("R8 enable after soft reset", en, 2'b11);
    endtask

    initial begin
        t_reset();
        t_static_hz();
        t_stuck_high();
        t_collide();
        t_soft_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule